// File: doc/BRIEF.md
# Output buffer sequence tracker

This block keeps the record of which output frame buffers are currently armed for a memory-writing scaler or rotator. Software arms or releases one buffer per request by giving a buffer index and choosing enqueue or dequeue. A dedicated arm strobe, used whenever a fresh output address is programmed, always arms buffer 0. The block holds an occupancy mask with one bit per buffer and keeps a registered count of the set bits.

The frame-done interrupt enable follows that count with hysteresis. An enqueue that leaves two or more buffers armed turns the enable on. A dequeue that leaves one or none armed turns it off. Every other case leaves the enable where it was. Turning the enable on also selects level-type signalling and masks the overflow interrupt. A stop command or a software reset empties the mask.

When a frame ends, the block turns the frame counters into the index of the buffer that was just completed. It uses the previous-frame counter if that is nonzero, and otherwise the present-frame counter. It reports that value minus one on a one-cycle done pulse. If both counters are zero, it raises an error flag instead.

Top module: `outbuf_seq_tracker`

## Requirements
- R1: An enqueue request sets bit [index] of `buf_mask` and a dequeue request clears it. The new mask appears on the first rising edge after the request cycle.
- R2: `buf_count` always equals the number of set bits in `buf_mask`, and it updates on the same edge as the mask.
- R3: An enqueue that leaves `buf_count` at 2 or more sets `irq_en` on that edge. On the same edge it sets `irq_level` to 1 and clears `ovf_irq_en` to 0.
- R4: A dequeue that leaves `buf_count` at 1 or less clears `irq_en` on that edge.
- R5: In every other cycle `irq_en` keeps its value. This includes enqueues that leave a count below 2, dequeues that leave a count of 2 or more, and cycles with no request.
- R6: `stop` or `sw_reset` clears `buf_mask`, `buf_count` and `irq_en`, and overrides any request in the same cycle. After `rst_n` is released, `buf_mask`=0, `irq_en`=0, `irq_level`=0, `ovf_irq_en`=1 and `done_pulse`=0.
- R7: When an enqueue and a dequeue arrive in the same cycle, the dequeue is applied first. An equal index therefore leaves the bit set.
- R8: A request whose index is NBUF (32) or larger has no effect on the mask.
- R9: `arm_addr` acts as an enqueue of index 0, including for the enable rule of R3.
- R10: A `frame_end` cycle gives `done_pulse`=1 for exactly the next cycle. In that cycle `done_idx` = `prev_cnt`-1 if `prev_cnt` is nonzero, and `pres_cnt`-1 otherwise.
- R11: When `prev_cnt` and `pres_cnt` are both 0 at a frame end, `done_err`=1 with the done pulse and `done_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Software reset, clears the mask |
| stop | input | 1 | Stop command, clears the mask |
| enq_valid | input | 1 | Enqueue request |
| enq_idx | input | 6 | Buffer index to enqueue |
| deq_valid | input | 1 | Dequeue request |
| deq_idx | input | 6 | Buffer index to dequeue |
| arm_addr | input | 1 | Output address armed; enqueues buffer 0 |
| frame_end | input | 1 | End of the frame being written |
| prev_cnt | input | 6 | Previous-frame counter |
| pres_cnt | input | 6 | Present-frame counter |
| buf_mask | output | 32 | Armed buffer mask |
| buf_count | output | 6 | Number of armed buffers |
| irq_en | output | 1 | Frame interrupt enable |
| irq_level | output | 1 | Level-type interrupt select |
| ovf_irq_en | output | 1 | Overflow interrupt enable |
| done_pulse | output | 1 | Completed-buffer report valid |
| done_idx | output | 6 | Completed buffer index |
| done_err | output | 1 | Both frame counters were zero |

## Verification
The bench walks the count back and forth across the thresholds: 2 to 3 and back to 2, and re-arming or re-releasing a buffer that is already in that state. A design without hysteresis would drop the enable at a count of 2. It also drives an enqueue and a dequeue of the same buffer in one cycle, where the wrong priority loses the bit, and indices of 32 and above, which an unchecked decoder would wrap onto low buffers. For frame ends it covers the fallback to the present counter and the all-zero case, where a design without the error path would report index 63.

// File: rtl/outbuf_seq_tracker.sv
module outbuf_seq_tracker #(
  parameter int NBUF      = 32,
  parameter int IDX_W     = 6,
  parameter int FCNT_W    = 6,
  parameter int ARM_TH    = 2,
  parameter int DISARM_TH = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_reset,
  input  logic                       stop,
  input  logic                       enq_valid,
  input  logic [IDX_W-1:0]           enq_idx,
  input  logic                       deq_valid,
  input  logic [IDX_W-1:0]           deq_idx,
  input  logic                       arm_addr,
  input  logic                       frame_end,
  input  logic [FCNT_W-1:0]          prev_cnt,
  input  logic [FCNT_W-1:0]          pres_cnt,
  output logic [NBUF-1:0]            buf_mask,
  output logic [$clog2(NBUF+1)-1:0]  buf_count,
  output logic                       irq_en,
  output logic                       irq_level,
  output logic                       ovf_irq_en,
  output logic                       done_pulse,
  output logic [FCNT_W-1:0]          done_idx,
  output logic                       done_err
);
  localparam int CNT_W = $clog2(NBUF+1);
  localparam logic [IDX_W:0]   IDX_LIM = (IDX_W+1)'(NBUF);
  localparam logic [CNT_W-1:0] ON_TH   = CNT_W'(ARM_TH);
  localparam logic [CNT_W-1:0] OFF_TH  = CNT_W'(DISARM_TH);

  function automatic logic [CNT_W-1:0] popc(input logic [NBUF-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NBUF; i++) s = s + CNT_W'(v[i]);
    return s;
  endfunction

  wire enq_ok  = enq_valid && ({1'b0, enq_idx} < IDX_LIM);
  wire deq_ok  = deq_valid && ({1'b0, deq_idx} < IDX_LIM);
  wire enq_any = enq_ok || arm_addr;
  wire clr     = sw_reset || stop;

  wire [NBUF-1:0] enq_bit = enq_ok   ? (NBUF'(1) << enq_idx) : '0;
  wire [NBUF-1:0] deq_bit = deq_ok   ? (NBUF'(1) << deq_idx) : '0;
  wire [NBUF-1:0] arm_bit = arm_addr ? NBUF'(1) : '0;

  wire [NBUF-1:0]  mask_nx = (buf_mask & ~deq_bit) | enq_bit | arm_bit;
  wire [CNT_W-1:0] cnt_nx  = popc(mask_nx);

  wire [FCNT_W-1:0] fsel = (prev_cnt != '0) ? prev_cnt : pres_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_mask   <= '0;
      buf_count  <= '0;
      irq_en     <= 1'b0;
      irq_level  <= 1'b0;
      ovf_irq_en <= 1'b1;
    end else if (clr) begin
      buf_mask   <= '0;
      buf_count  <= '0;
      irq_en     <= 1'b0;
    end else begin
      buf_mask  <= mask_nx;
      buf_count <= cnt_nx;
      if (enq_any && cnt_nx >= ON_TH) begin
        irq_en     <= 1'b1;
        irq_level  <= 1'b1;
        ovf_irq_en <= 1'b0;
      end else if (deq_ok && cnt_nx <= OFF_TH) begin
        irq_en <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pulse <= 1'b0;
      done_err   <= 1'b0;
      done_idx   <= '0;
    end else begin
      done_pulse <= frame_end;
      done_err   <= frame_end && (fsel == '0);
      done_idx   <= (frame_end && fsel != '0) ? fsel - FCNT_W'(1) : '0;
    end
  end
endmodule

// File: rtl/outbuf_seq_tracker_chk.sv
module outbuf_seq_tracker_chk #(
  parameter int NBUF      = 32,
  parameter int IDX_W     = 6,
  parameter int FCNT_W    = 6,
  parameter int ARM_TH    = 2,
  parameter int DISARM_TH = 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sw_reset,
  input logic                       stop,
  input logic                       enq_valid,
  input logic [IDX_W-1:0]           enq_idx,
  input logic                       deq_valid,
  input logic [IDX_W-1:0]           deq_idx,
  input logic                       arm_addr,
  input logic                       frame_end,
  input logic [NBUF-1:0]            buf_mask,
  input logic [$clog2(NBUF+1)-1:0]  buf_count,
  input logic                       irq_en,
  input logic                       irq_level,
  input logic                       ovf_irq_en,
  input logic                       done_pulse,
  input logic [FCNT_W-1:0]          done_idx,
  input logic                       done_err
);
  localparam int CNT_W = $clog2(NBUF+1);
  localparam logic [IDX_W:0]   LIM = (IDX_W+1)'(NBUF);
  localparam logic [CNT_W-1:0] ON  = CNT_W'(ARM_TH);
  localparam logic [CNT_W-1:0] OFF = CNT_W'(DISARM_TH);

  wire clr     = sw_reset || stop;
  wire enq_ok  = enq_valid && ({1'b0, enq_idx} < LIM);
  wire deq_ok  = deq_valid && ({1'b0, deq_idx} < LIM);
  wire enq_any = enq_ok || arm_addr;
  wire bad_enq = enq_valid && !enq_ok;

  assert_popcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_count == CNT_W'($countones(buf_mask)));

  assert_arm_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && enq_any) |=> (buf_count < ON || (irq_en && irq_level && !ovf_irq_en)));

  assert_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && deq_ok) |=> (buf_count > OFF || !irq_en));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !enq_any && !deq_ok) |=> $stable(irq_en));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (buf_mask == '0 && !irq_en));

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bad_enq && !arm_addr && !deq_ok) |=> $stable(buf_mask));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> done_pulse);

  assert_nopulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !done_pulse);

  assert_error_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> (done_pulse && done_idx == '0));
endmodule

bind outbuf_seq_tracker outbuf_seq_tracker_chk #(
  .NBUF(NBUF), .IDX_W(IDX_W), .FCNT_W(FCNT_W), .ARM_TH(ARM_TH), .DISARM_TH(DISARM_TH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .stop(stop),
  .enq_valid(enq_valid), .enq_idx(enq_idx), .deq_valid(deq_valid), .deq_idx(deq_idx),
  .arm_addr(arm_addr), .frame_end(frame_end), .buf_mask(buf_mask), .buf_count(buf_count),
  .irq_en(irq_en), .irq_level(irq_level), .ovf_irq_en(ovf_irq_en),
  .done_pulse(done_pulse), .done_idx(done_idx), .done_err(done_err)
);

// File: tb/sim_outbuf_seq_tracker.sv
`timescale 1ns/1ps
module sim_outbuf_seq_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_reset = 0, stop = 0, enq_valid = 0, deq_valid = 0, arm_addr = 0, frame_end = 0;
  logic [5:0] enq_idx = '0, deq_idx = '0, prev_cnt = '0, pres_cnt = '0;
  logic [31:0] buf_mask;
  logic [5:0]  buf_count, done_idx;
  logic irq_en, irq_level, ovf_irq_en, done_pulse, done_err;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  outbuf_seq_tracker u0 (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .stop(stop),
    .enq_valid(enq_valid), .enq_idx(enq_idx), .deq_valid(deq_valid), .deq_idx(deq_idx),
    .arm_addr(arm_addr), .frame_end(frame_end), .prev_cnt(prev_cnt), .pres_cnt(pres_cnt),
    .buf_mask(buf_mask), .buf_count(buf_count), .irq_en(irq_en), .irq_level(irq_level),
    .ovf_irq_en(ovf_irq_en), .done_pulse(done_pulse), .done_idx(done_idx), .done_err(done_err));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(bit ev, int ei, bit dv, int di, bit arm, bit stp, bit swr);
    @(negedge clk);
    enq_valid = ev; enq_idx = 6'(ei); deq_valid = dv; deq_idx = 6'(di);
    arm_addr = arm; stop = stp; sw_reset = swr;
    @(posedge clk); #1;
    enq_valid = 0; deq_valid = 0; arm_addr = 0; stop = 0; sw_reset = 0;
  endtask

  task automatic expect_state(string req, logic [31:0] m, int c, bit irq);
    check({req, " mask"}, buf_mask, m);
    check({req, " count"}, 32'(buf_count), 32'(c));
    check({req, " irq_en"}, 32'(irq_en), 32'(irq));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    expect_state("R6 reset", 32'h0, 0, 0);
    check("R6 reset irq_level", 32'(irq_level), 0);
    check("R6 reset ovf_irq_en", 32'(ovf_irq_en), 1);
    check("R6 reset done_pulse", 32'(done_pulse), 0);
  endtask

  task automatic t_basic;
    step(1, 3, 0, 0, 0, 0, 0);
    expect_state("R1 R2 enq3 below threshold", 32'h8, 1, 0);
    step(1, 31, 0, 0, 0, 0, 0);
    expect_state("R3 enq31", 32'h8000_0008, 2, 1);
    check("R3 irq_level", 32'(irq_level), 1);
    check("R3 ovf_irq_en", 32'(ovf_irq_en), 0);
  endtask

  task automatic t_ignore;
    step(1, 40, 0, 0, 0, 0, 0);
    expect_state("R8 enq40", 32'h8000_0008, 2, 1);
    step(1, 32, 0, 0, 0, 0, 0);
    expect_state("R8 enq32", 32'h8000_0008, 2, 1);
    step(0, 0, 1, 35, 0, 0, 0);
    expect_state("R8 deq35", 32'h8000_0008, 2, 1);
  endtask

  task automatic t_disarm;
    step(0, 0, 1, 3, 0, 0, 0);
    expect_state("R4 deq3", 32'h8000_0000, 1, 0);
  endtask

  task automatic t_hyst;
    step(1, 5, 0, 0, 0, 0, 0);
    expect_state("R3 enq5", 32'h8000_0020, 2, 1);
    step(1, 6, 0, 0, 0, 0, 0);
    expect_state("R5 enq6", 32'h8000_0060, 3, 1);
    step(0, 0, 1, 6, 0, 0, 0);
    expect_state("R5 deq6 stays on", 32'h8000_0020, 2, 1);
    step(1, 5, 0, 0, 0, 0, 0);
    expect_state("R5 re-enq5", 32'h8000_0020, 2, 1);
    step(0, 0, 1, 5, 0, 0, 0);
    expect_state("R4 deq5", 32'h8000_0000, 1, 0);
    step(0, 0, 1, 5, 0, 0, 0);
    expect_state("R4 re-deq5", 32'h8000_0000, 1, 0);
    step(1, 7, 0, 0, 0, 0, 0);
    expect_state("R3 enq7", 32'h8000_0080, 2, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    expect_state("R5 idle", 32'h8000_0080, 2, 1);
  endtask

  task automatic t_same;
    step(1, 5, 1, 5, 0, 0, 0);
    expect_state("R7 enq5+deq5", 32'h8000_00A0, 3, 1);
    step(1, 7, 1, 7, 0, 0, 0);
    expect_state("R7 enq7+deq7", 32'h8000_00A0, 3, 1);
  endtask

  task automatic t_arm_stop;
    step(0, 0, 0, 0, 1, 0, 0);
    expect_state("R9 arm", 32'h8000_00A1, 4, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    expect_state("R6 stop", 32'h0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    expect_state("R9 arm alone", 32'h1, 1, 0);
    step(1, 9, 0, 0, 0, 0, 0);
    expect_state("R3 enq9", 32'h201, 2, 1);
    step(1, 4, 0, 0, 0, 1, 0);
    expect_state("R6 stop beats enq", 32'h0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    expect_state("R9 arm reaches threshold", 32'h3, 2, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    expect_state("R6 sw_reset", 32'h0, 0, 0);
  endtask

  task automatic frame(int p, int q, bit pulse, int idx, bit err, string req);
    @(negedge clk);
    frame_end = 1; prev_cnt = 6'(p); pres_cnt = 6'(q);
    @(posedge clk); #1;
    frame_end = 0;
    check({req, " done_pulse"}, 32'(done_pulse), 32'(pulse));
    check({req, " done_idx"}, 32'(done_idx), 32'(idx));
    check({req, " done_err"}, 32'(done_err), 32'(err));
  endtask

  task automatic t_frame;
    frame(4, 7, 1, 3, 0, "R10 prev used");
    @(posedge clk); #1;
    check("R10 pulse one cycle", 32'(done_pulse), 0);
    frame(0, 1, 1, 0, 0, "R10 fallback present");
    frame(63, 0, 1, 62, 0, "R10 prev max");
    frame(0, 0, 1, 0, 1, "R11 both zero");
    @(posedge clk); #1;
    check("R11 err clears", 32'(done_err), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_basic;
    t_ignore;
    t_disarm;
    t_hyst;
    t_same;
    t_arm_stop;
    t_frame;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule